// File: doc/BRIEF.md
# Signed Non-Restoring Sequential Divider

This block divides one signed two's-complement integer by another over several clock cycles. It uses radix-2 non-restoring iteration and produces one quotient digit per clock. Each digit is either plus one or minus one. The quotient truncates toward zero. The remainder is an integer that carries the sign of the dividend.

A request is a one-cycle start pulse with both operands present on the inputs. The block then raises busy while it iterates and signals the end with a one-cycle done pulse. On that same edge it updates the quotient, the remainder and two flags. These outputs hold until the next accepted request completes.

The operation can finish early in two ways. When the partial remainder reaches zero, the remaining digits are dropped. A zero divisor ends the request at once. Whatever the path, a negative divisor negates the quotient.

Top module: `sdiv_nr`

## Requirements
- R1: After reset, busy, done, div_zero and overflow are 0, and quotient and remainder are 0.
- R2: For a nonzero divisor, other than the overflow case, the quotient equals the dividend divided by the divisor, truncated toward zero.
- R3: For a nonzero divisor, the remainder equals dividend minus quotient times divisor. It is zero or has the sign of the dividend, and its magnitude is below the magnitude of the divisor.
- R4: Negating a divisor other than the most negative value negates the quotient and leaves the remainder unchanged.
- R5: A zero divisor sets div_zero to 1 and forces quotient and remainder to 0. Done appears no more than 2 cycles after the cycle in which start was sampled.
- R6: A dividend of -2048 divided by -1 (the defaults) sets overflow to 1. The quotient is then -2048, which is the wrapped value of +2048, and the remainder is 0. Overflow is 0 for every other operand pair.
- R7: When the partial remainder reaches zero, the operation ends early. A zero dividend finishes within 3 cycles, and a dividend of -2048 divided by 1 finishes within 4 cycles.
- R8: Busy is 1 in the cycle after start is accepted and stays 1 until done. Done lasts exactly one cycle and is never high together with busy. Every operation finishes within M+2 cycles.
- R9: A start pulse while busy is ignored: the result belongs to the first operands. The outputs hold steady while an operation runs and after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| dividend | input | M | Signed dividend |
| divisor | input | M | Signed divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | M | Signed quotient |
| remainder | output | M | Signed remainder |
| div_zero | output | 1 | Last operation had a zero divisor |
| overflow | output | 1 | Last operation was most negative divided by -1 |

## Verification
The bench covers the four sign combinations of dividend and divisor. This catches a design that skips the final correction: it would leave remainders with the wrong sign and quotients off by one. It also covers exact divisions and a zero dividend. A design that mishandled early exit would miss the latency bounds or keep stale digits in the quotient.

Three corner cases get their own directed requests. The first is the most negative dividend with divisors of 1, -1 and 2047. The second is a zero divisor, which would corrupt the outputs if the block iterated on it. The third is a second start sent while the block is busy; a block that accepted it would report the wrong operands' result. Random operand pairs, biased toward small divisors, are checked against truncating division computed in the bench.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } sdiv_state_t;
endpackage

// File: rtl/sdiv_step.sv
module sdiv_step #(
  parameter int W  = 12,
  parameter int RW = 2 * W + 1,
  parameter int JW = $clog2(W)
) (
  input  logic signed [RW-1:0] r_in,
  input  logic        [W-1:0]  dmag,
  input  logic        [JW-1:0] jpos,
  output logic signed [RW-1:0] r_out,
  output logic                 dig_pos
);
  logic [RW-1:0] shifted;

  assign shifted = {{(RW-W){1'b0}}, dmag} << jpos;
  assign dig_pos = ~r_in[RW-1];
  assign r_out   = dig_pos ? (r_in - $signed(shifted)) : (r_in + $signed(shifted));
endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix #(
  parameter int W  = 12,
  parameter int RW = 2 * W + 1
) (
  input  logic signed [RW-1:0] r_in,
  input  logic        [W-1:0]  dmag,
  input  logic        [W-1:0]  pmask,
  input  logic        [W-1:0]  umask,
  input  logic                 a_pos,
  input  logic                 a_neg,
  input  logic                 b_neg,
  input  logic                 dz,
  output logic        [W-1:0]  q_out,
  output logic        [W-1:0]  r_out
);
  localparam int QW = W + 2;

  logic [QW-1:0] q_raw, q_cor, q_sgn;
  logic [RW-1:0] r_cor, d_ext;

  assign q_raw = {1'b0, pmask, 1'b0} - {2'b00, umask};
  assign d_ext = {{(RW-W){1'b0}}, dmag};

  always_comb begin
    q_cor = q_raw;
    r_cor = r_in;
    if (a_pos && r_in[RW-1]) begin
      r_cor = r_in + d_ext;
      q_cor = q_raw - QW'(1);
    end else if (a_neg && !r_in[RW-1] && (r_in != '0)) begin
      r_cor = r_in - d_ext;
      q_cor = q_raw + QW'(1);
    end
    q_sgn = b_neg ? (QW'(0) - q_cor) : q_cor;
    q_out = dz ? '0 : q_sgn[W-1:0];
    r_out = dz ? '0 : r_cor[W-1:0];
  end
endmodule

// File: rtl/sdiv_nr.sv
module sdiv_nr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_zero,
  output logic         overflow
);
  import sdiv_pkg::*;

  localparam int RW = 2 * W + 1;
  localparam int JW = $clog2(W);
  localparam logic [JW-1:0] JTOP = JW'(W - 1);
  localparam logic [W-1:0]  MOSTNEG = {1'b1, {(W-1){1'b0}}};

  sdiv_state_t        st;
  logic signed [RW-1:0] pr;
  logic [W-1:0]       dmag, pmask, umask;
  logic [JW-1:0]      jx;
  logic               a_pos, a_neg, b_neg, dz, ov;

  logic signed [RW-1:0] step_r;
  logic               step_pos;
  logic [W-1:0]       fix_q, fix_r;
  logic [W-1:0]       abs_div;

  assign abs_div = divisor[W-1] ? (W'(0) - divisor) : divisor;

  sdiv_step #(.W(W), .RW(RW), .JW(JW)) u_step (
    .r_in   (pr),
    .dmag   (dmag),
    .jpos   (jx),
    .r_out  (step_r),
    .dig_pos(step_pos)
  );

  sdiv_fix #(.W(W), .RW(RW)) u_fix (
    .r_in  (pr),
    .dmag  (dmag),
    .pmask (pmask),
    .umask (umask),
    .a_pos (a_pos),
    .a_neg (a_neg),
    .b_neg (b_neg),
    .dz    (dz),
    .q_out (fix_q),
    .r_out (fix_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pr        <= '0;
      dmag      <= '0;
      pmask     <= '0;
      umask     <= '0;
      jx        <= '0;
      a_pos     <= 1'b0;
      a_neg     <= 1'b0;
      b_neg     <= 1'b0;
      dz        <= 1'b0;
      ov        <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          done <= 1'b0;
          if (start) begin
            pr    <= {{(RW-W){dividend[W-1]}}, dividend};
            dmag  <= abs_div;
            pmask <= '0;
            umask <= '0;
            jx    <= JTOP;
            a_neg <= dividend[W-1];
            a_pos <= !dividend[W-1] && (dividend != '0);
            b_neg <= divisor[W-1];
            dz    <= (divisor == '0);
            ov    <= (dividend == MOSTNEG) && (&divisor);
            busy  <= 1'b1;
            st    <= (divisor == '0) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (pr == '0) begin
            st <= ST_FIN;
          end else begin
            pr        <= step_r;
            pmask[jx] <= step_pos;
            umask[jx] <= 1'b1;
            if (jx == '0) st <= ST_FIN;
            else          jx <= jx - JW'(1);
          end
        end
        ST_FIN: begin
          quotient  <= fix_q;
          remainder <= fix_r;
          div_zero  <= dz;
          overflow  <= ov;
          done      <= 1'b1;
          busy      <= 1'b0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdiv_nr_chk.sv
module sdiv_nr_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_zero,
  input logic         overflow
);
  logic         cap_neg;
  logic [W-1:0] cap_mag;
  logic [W-1:0] rem_mag;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_neg <= 1'b0;
      cap_mag <= '0;
    end else if (start && !busy && !done) begin
      cap_neg <= dividend[W-1];
      cap_mag <= divisor[W-1] ? (W'(0) - divisor) : divisor;
    end
  end

  assign rem_mag = remainder[W-1] ? (W'(0) - remainder) : remainder;

  assert_rem_sign_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !div_zero && remainder != '0) |-> (remainder[W-1] == cap_neg));
  assert_rem_mag_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !div_zero) |-> (rem_mag < cap_mag));
  assert_zero_div_R5: assert property (@(posedge clk) disable iff (rst)
    (done && div_zero) |-> (quotient == '0 && remainder == '0));
  assert_ovf_R6: assert property (@(posedge clk) disable iff (rst)
    (done && overflow) |-> (remainder == '0 && quotient == {1'b1, {(W-1){1'b0}}}));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($stable(quotient) && $stable(remainder)));
endmodule

bind sdiv_nr sdiv_nr_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
  .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
  .div_zero(div_zero), .overflow(overflow)
);

// File: tb/tb_sdiv_nr.sv
module tb_sdiv_nr;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_zero, overflow;
  logic [W-1:0] quotient, remainder;

  int n_chk = 0;
  int n_bad = 0;

  sdiv_nr #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .div_zero(div_zero), .overflow(overflow)
  );

  always #4 clk = ~clk;

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int sx(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic run_op(input int a, input int b, input string tag, input bit poke,
                        input int max_lat);
    int eq, er, edz, eov, lat;
    logic [W-1:0] hq, hr;
    if (b == 0) begin
      eq = 0; er = 0; edz = 1; eov = 0;
    end else if (a == -2048 && b == -1) begin
      eq = -2048; er = 0; edz = 0; eov = 1;
    end else begin
      eq = a / b; er = a % b; edz = 0; eov = 0;
    end
    @(negedge clk);
    dividend = W'(a);
    divisor  = W'(b);
    start    = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      start = poke && (lat == 2);
      if (poke && lat == 2) begin
        dividend = W'(5);
        divisor  = W'(3);
      end
      if (lat == 1 && b != 0) check({tag, " R8 busy"}, int'(busy), 1);
    end while (!done && lat < 40);
    start = 1'b0;
    check({tag, " R8 latency bound"}, int'(lat <= max_lat), 1);
    check({tag, " quotient"}, sx(quotient), eq);
    check({tag, " remainder"}, sx(remainder), er);
    check({tag, " R5 div_zero"}, int'(div_zero), edz);
    check({tag, " R6 overflow"}, int'(overflow), eov);
    hq = quotient;
    hr = remainder;
    @(negedge clk);
    check({tag, " R8 done one cycle"}, int'(done), 0);
    check({tag, " R9 hold"}, int'(quotient == hq && remainder == hr), 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset quotient", sx(quotient), 0);
    check("R1 reset remainder", sx(remainder), 0);
    check("R1 reset flags", int'(div_zero | overflow), 0);

    run_op(7, 2, "R2 pos/pos", 0, W + 2);
    run_op(-7, 2, "R3 neg/pos", 0, W + 2);
    run_op(7, -2, "R4 pos/neg", 0, W + 2);
    run_op(-7, -2, "R4 neg/neg", 0, W + 2);
    run_op(100, 7, "R4 base", 0, W + 2);
    run_op(100, -7, "R4 negated", 0, W + 2);
    run_op(2047, 1, "R2 max", 0, W + 2);
    run_op(-2048, 2047, "R3 mostneg", 0, W + 2);
    run_op(1, -2048, "R3 small", 0, W + 2);
    run_op(-2048, -2048, "R2 equal", 0, W + 2);
    run_op(5, 0, "R5 zero divisor", 0, 2);
    run_op(-2048, -1, "R6 overflow case", 0, W + 2);
    run_op(2047, -1, "R6 near overflow", 0, W + 2);
    run_op(0, 9, "R7 zero dividend", 0, 3);
    run_op(-2048, 1, "R7 early exit", 0, 4);
    run_op(1234, -5, "R9 start while busy", 1, W + 2);
    run_op(-999, 37, "R9 start while busy", 1, W + 2);

    for (int i = 0; i < 400; i++) begin
      int a, b;
      a = sx(W'($urandom));
      if ($urandom % 3 == 0) b = int'($urandom % 17) - 8;
      else b = sx(W'($urandom));
      run_op(a, b, "R2 random", 0, W + 2);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule